// File: doc/BRIEF.md
# USB IN-Endpoint Handshake and Transfer-Request Controller

This block sits on the device side of a USB function, between the token decoder and the packet transmitter. It serves a configurable number of IN endpoints: the control-IN endpoint and further IN endpoints, which is three in the default build. For each IN token it selects one of two answers. If firmware has not yet committed a packet, it answers NAK. If firmware has armed the endpoint, it starts data transmission. Each endpoint keeps a "data ready" bit and a transfer-request flag. The flag is raised only after the NAK handshake has actually gone out on the bus. Every further NAKed token raises the flag again, even after firmware has cleared it, until firmware arms the packet.

The data-ready bit is cleared when the host acknowledges the packet. It is left set on an acknowledge timeout, so the next IN token retransmits the same packet. An interrupt line combines the flags, each masked by its own enable bit.

A separate guard handles clear requests for the bulk OUT FIFO. A clear request is dropped while DMA is enabled on that endpoint. Firmware must disable DMA first.

Tokens arrive on a valid/ready stream. `tok_ready` is high only when no transaction is outstanding. A token presented while `tok_ready` is low stays pending and is taken on the first edge where both signals are high. A token addressing an index at or above the endpoint count is consumed without any response.

Top module: `usb_in_nak_ctrl`

## Requirements
- R1: After reset, every transfer-request flag is 0, no endpoint has data ready, DMA is off, `tok_ready` is 1, and `irq` and `out_fifo_clr` are 0.
- R2: A token accepted for an endpoint without data ready produces `resp_nak`=1 for exactly one cycle, starting the cycle after acceptance, with `resp_ep` equal to the token's endpoint.
- R3: The flag of an endpoint is not set when its token is accepted. It becomes 1 on the cycle after the `nak_sent` strobe that closes that NAK transaction.
- R4: A token arriving before firmware arms the endpoint is NAKed again, and the flag is set again even if firmware cleared it in between.
- R5: After a one-cycle `pkt_arm` pulse for an endpoint, its next accepted token produces `resp_data`=1 for one cycle and no `resp_nak`. No flag is set for that transaction.
- R6: A `host_ack` during a data transaction clears that endpoint's data-ready bit, so its next token is NAKed.
- R7: An `ack_timeout` during a data transaction leaves the data-ready bit set, so the next token starts data again.
- R8: When a flag set and a `flag_clr` bit for the same endpoint fall in the same cycle, the flag ends at 1. A lone `flag_clr` bit clears the flag on the next cycle.
- R9: `irq` is 1 exactly when some endpoint has both its flag and its `irq_en` bit set.
- R10: A `fifo_clr_req` yields a one-cycle `out_fifo_clr` on the next cycle only when DMA is off. While `dma_on` is 1 the request has no effect. `dma_wr` loads `dma_wdata` into `dma_on`.
- R11: `tok_ready` is 0 from the edge that accepts a token until the closing handshake strobe (`nak_sent` for NAK, `host_ack` or `ack_timeout` for data). A token held during that time is not consumed, and is then accepted. A token whose endpoint index is at or above the endpoint count is consumed with no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tok_valid | input | 1 | IN token present |
| tok_ep | input | EPW | Endpoint index of the token |
| tok_ready | output | 1 | Controller can take a token |
| nak_sent | input | 1 | NAK handshake has been sent |
| host_ack | input | 1 | Host ACK received for data packet |
| ack_timeout | input | 1 | No ACK arrived for data packet |
| pkt_arm | input | NUM_EP | Per-endpoint packet-enable trigger pulse |
| flag_clr | input | NUM_EP | Per-endpoint write-one-to-clear for flags |
| irq_en | input | NUM_EP | Per-endpoint interrupt enable |
| dma_wr | input | 1 | Write strobe for DMA enable |
| dma_wdata | input | 1 | Value written to DMA enable |
| fifo_clr_req | input | 1 | Request to clear the bulk OUT FIFO |
| resp_nak | output | 1 | Select NAK handshake (one-cycle pulse) |
| resp_data | output | 1 | Start data transmission (one-cycle pulse) |
| resp_ep | output | EPW | Endpoint of the current transaction |
| tr_flag | output | NUM_EP | Transfer-request flags |
| irq | output | 1 | Masked OR of the flags |
| dma_on | output | 1 | DMA enable state |
| out_fifo_clr | output | 1 | Clear pulse to the OUT FIFO |

## Verification
A table walks several token patterns across the endpoints:
- an unarmed token, which must give NAK and a late flag;
- an armed token closed by ACK, which must give data and then NAK on the next try;
- an armed token closed by timeout, which must give data on the retry.

Together these separate the three sources of the data-ready bit. The repeated-NAK rows after a firmware clear distinguish a flag raised per NAK from one raised once. The directed cases do the following:
- overlap a set with a clear to distinguish set-priority from clear-priority;
- hold a token under back-pressure to confirm it is neither lost nor taken early;
- toggle DMA around FIFO clear requests to show that the block is enabled only when DMA is off.

// File: rtl/usb_in_pkg.sv
package usb_in_pkg;
  typedef enum logic [1:0] {
    TXN_IDLE = 2'd0,
    TXN_NAK  = 2'd1,
    TXN_DATA = 2'd2
  } txn_state_e;
endpackage

// File: rtl/usb_in_txn_seq.sv
module usb_in_txn_seq
  import usb_in_pkg::*;
#(
  parameter int NUM_EP = 3,
  parameter int EPW    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tok_valid,
  input  logic [EPW-1:0]    tok_ep,
  output logic              tok_ready,
  input  logic [NUM_EP-1:0] rdy_vec,
  input  logic              nak_sent,
  input  logic              host_ack,
  input  logic              ack_timeout,
  output logic              resp_nak,
  output logic              resp_data,
  output logic [EPW-1:0]    resp_ep,
  output logic [NUM_EP-1:0] nak_set,
  output logic [NUM_EP-1:0] ack_clr
);
  localparam int SLOTS = 1 << EPW;

  txn_state_e     state_q;
  logic [EPW-1:0] cur_ep_q;
  logic [SLOTS-1:0] rdy_pad;
  logic           accept;
  logic           in_range;

  assign rdy_pad   = SLOTS'(rdy_vec);
  assign tok_ready = (state_q == TXN_IDLE);
  assign accept    = tok_valid && tok_ready;
  assign in_range  = (32'(tok_ep) < NUM_EP);
  assign resp_ep   = cur_ep_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= TXN_IDLE;
      cur_ep_q  <= '0;
      resp_nak  <= 1'b0;
      resp_data <= 1'b0;
    end else begin
      resp_nak  <= 1'b0;
      resp_data <= 1'b0;
      unique case (state_q)
        TXN_IDLE: begin
          if (accept && in_range) begin
            cur_ep_q <= tok_ep;
            if (rdy_pad[tok_ep]) begin
              resp_data <= 1'b1;
              state_q   <= TXN_DATA;
            end else begin
              resp_nak  <= 1'b1;
              state_q   <= TXN_NAK;
            end
          end
        end
        TXN_NAK: begin
          if (nak_sent) state_q <= TXN_IDLE;
        end
        TXN_DATA: begin
          if (host_ack || ack_timeout) state_q <= TXN_IDLE;
        end
        default: state_q <= TXN_IDLE;
      endcase
    end
  end

  for (genvar g = 0; g < NUM_EP; g++) begin : g_sel
    assign nak_set[g] = (state_q == TXN_NAK)  && nak_sent && (32'(cur_ep_q) == g);
    assign ack_clr[g] = (state_q == TXN_DATA) && host_ack && (32'(cur_ep_q) == g);
  end
endmodule

// File: rtl/usb_in_ep_state.sv
module usb_in_ep_state (
  input  logic clk,
  input  logic rst_n,
  input  logic pkt_arm,
  input  logic ack_clr,
  input  logic nak_set,
  input  logic flag_clr,
  output logic data_rdy,
  output logic tr_flag
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data_rdy <= 1'b0;
      tr_flag  <= 1'b0;
    end else begin
      if (pkt_arm)      data_rdy <= 1'b1;
      else if (ack_clr) data_rdy <= 1'b0;
      if (nak_set)       tr_flag <= 1'b1;
      else if (flag_clr) tr_flag <= 1'b0;
    end
  end
endmodule

// File: rtl/usb_out_clr_guard.sv
module usb_out_clr_guard (
  input  logic clk,
  input  logic rst_n,
  input  logic dma_wr,
  input  logic dma_wdata,
  input  logic fifo_clr_req,
  output logic dma_on,
  output logic out_fifo_clr
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dma_on       <= 1'b0;
      out_fifo_clr <= 1'b0;
    end else begin
      if (dma_wr) dma_on <= dma_wdata;
      out_fifo_clr <= fifo_clr_req && !dma_on;
    end
  end
endmodule

// File: rtl/usb_in_nak_ctrl.sv
module usb_in_nak_ctrl #(
  parameter  int NUM_EP = 3,
  localparam int EPW    = (NUM_EP > 1) ? $clog2(NUM_EP) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tok_valid,
  input  logic [EPW-1:0]    tok_ep,
  output logic              tok_ready,
  input  logic              nak_sent,
  input  logic              host_ack,
  input  logic              ack_timeout,
  input  logic [NUM_EP-1:0] pkt_arm,
  input  logic [NUM_EP-1:0] flag_clr,
  input  logic [NUM_EP-1:0] irq_en,
  input  logic              dma_wr,
  input  logic              dma_wdata,
  input  logic              fifo_clr_req,
  output logic              resp_nak,
  output logic              resp_data,
  output logic [EPW-1:0]    resp_ep,
  output logic [NUM_EP-1:0] tr_flag,
  output logic              irq,
  output logic              dma_on,
  output logic              out_fifo_clr
);
  logic [NUM_EP-1:0] data_rdy;
  logic [NUM_EP-1:0] nak_set;
  logic [NUM_EP-1:0] ack_clr;

  usb_in_txn_seq #(.NUM_EP(NUM_EP), .EPW(EPW)) u_seq (
    .clk, .rst_n, .tok_valid, .tok_ep, .tok_ready,
    .rdy_vec(data_rdy), .nak_sent, .host_ack, .ack_timeout,
    .resp_nak, .resp_data, .resp_ep, .nak_set, .ack_clr
  );

  for (genvar e = 0; e < NUM_EP; e++) begin : g_ep
    usb_in_ep_state u_ep (
      .clk, .rst_n,
      .pkt_arm (pkt_arm[e]),
      .ack_clr (ack_clr[e]),
      .nak_set (nak_set[e]),
      .flag_clr(flag_clr[e]),
      .data_rdy(data_rdy[e]),
      .tr_flag (tr_flag[e])
    );
  end

  assign irq = |(tr_flag & irq_en);

  usb_out_clr_guard u_guard (
    .clk, .rst_n, .dma_wr, .dma_wdata, .fifo_clr_req, .dma_on, .out_fifo_clr
  );
endmodule

// File: rtl/usb_in_nak_chk.sv
module usb_in_nak_chk #(
  parameter int NUM_EP = 3,
  parameter int EPW    = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tok_valid,
  input logic [EPW-1:0]    tok_ep,
  input logic              tok_ready,
  input logic              nak_sent,
  input logic              resp_nak,
  input logic              resp_data,
  input logic [NUM_EP-1:0] data_rdy,
  input logic [NUM_EP-1:0] tr_flag,
  input logic              dma_on,
  input logic              fifo_clr_req,
  input logic              out_fifo_clr
);
  localparam int SLOTS = 1 << EPW;
  logic [SLOTS-1:0] rdy_pad;
  logic             tok_take;
  assign rdy_pad  = SLOTS'(data_rdy);
  assign tok_take = tok_valid && tok_ready && (32'(tok_ep) < NUM_EP);

  assert_nak_unarmed_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tok_take && !rdy_pad[tok_ep] |=> resp_nak && !resp_data);

  assert_data_armed_R5: assert property (@(posedge clk) disable iff (!rst_n)
    tok_take && rdy_pad[tok_ep] |=> resp_data && !resp_nak);

  assert_clr_blocked_R10: assert property (@(posedge clk) disable iff (!rst_n)
    dma_on && fifo_clr_req |=> !out_fifo_clr);

  assert_busy_after_resp_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_nak || resp_data) |-> !tok_ready);

  for (genvar i = 0; i < NUM_EP; i++) begin : g_flag
    assert_flag_after_nak_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tr_flag[i]) |-> $past(nak_sent));
  end
endmodule

bind usb_in_nak_ctrl usb_in_nak_chk #(.NUM_EP(NUM_EP), .EPW(EPW)) u_chk (
  .clk(clk), .rst_n(rst_n), .tok_valid(tok_valid), .tok_ep(tok_ep),
  .tok_ready(tok_ready), .nak_sent(nak_sent), .resp_nak(resp_nak),
  .resp_data(resp_data), .data_rdy(data_rdy), .tr_flag(tr_flag),
  .dma_on(dma_on), .fifo_clr_req(fifo_clr_req), .out_fifo_clr(out_fifo_clr)
);

// File: tb/test_usb_in_nak_ctrl.sv
`timescale 1ns/1ps
module test_usb_in_nak_ctrl;
  localparam int N = 3;
  localparam int W = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tok_valid = 1'b0;
  logic [W-1:0] tok_ep = '0;
  logic tok_ready;
  logic nak_sent = 1'b0, host_ack = 1'b0, ack_timeout = 1'b0;
  logic [N-1:0] pkt_arm = '0, flag_clr = '0, irq_en = '0;
  logic dma_wr = 1'b0, dma_wdata = 1'b0, fifo_clr_req = 1'b0;
  logic resp_nak, resp_data, irq, dma_on, out_fifo_clr;
  logic [W-1:0] resp_ep;
  logic [N-1:0] tr_flag;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  usb_in_nak_ctrl #(.NUM_EP(N)) i_usb_in_nak_ctrl (
    .clk, .rst_n, .tok_valid, .tok_ep, .tok_ready, .nak_sent, .host_ack,
    .ack_timeout, .pkt_arm, .flag_clr, .irq_en, .dma_wr, .dma_wdata,
    .fifo_clr_req, .resp_nak, .resp_data, .resp_ep, .tr_flag, .irq,
    .dma_on, .out_fifo_clr
  );

  // row: {ep[1:0], arm, exp_data, fin[1:0]} fin 0=nak_sent 1=host_ack 2=ack_timeout
  localparam logic [5:0] VEC [8] = '{
    {2'd0, 1'b0, 1'b0, 2'd0},   // R2 R3 unarmed -> NAK, late flag
    {2'd1, 1'b1, 1'b1, 2'd1},   // R5 armed -> data, ACK
    {2'd1, 1'b0, 1'b0, 2'd0},   // R6 ACK cleared ready -> NAK
    {2'd2, 1'b1, 1'b1, 2'd2},   // R5 armed -> data, timeout
    {2'd2, 1'b0, 1'b1, 2'd1},   // R7 retransmit after timeout
    {2'd2, 1'b0, 1'b0, 2'd0},   // R6 after ACK -> NAK
    {2'd0, 1'b0, 1'b0, 2'd0},   // R4 NAK again after firmware clear
    {2'd0, 1'b1, 1'b1, 2'd1}    // R5 armed now -> data
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send_token(input int ep);
    tok_valid = 1'b1;
    tok_ep = W'(ep);
    @(negedge clk);
    tok_valid = 1'b0;
  endtask

  task automatic finish_txn(input int fin);
    nak_sent = (fin == 0);
    host_ack = (fin == 1);
    ack_timeout = (fin == 2);
    @(negedge clk);
    nak_sent = 1'b0; host_ack = 1'b0; ack_timeout = 1'b0;
  endtask

  task automatic clear_flag(input int ep);
    flag_clr[ep] = 1'b1;
    @(negedge clk);
    flag_clr = '0;
  endtask

  initial begin
    #100000;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 flags", 32'(tr_flag), 0);
    check("R1 tok_ready", 32'(tok_ready), 1);
    check("R1 dma_on", 32'(dma_on), 0);
    check("R1 irq", 32'(irq), 0);
    check("R1 fifo_clr", 32'(out_fifo_clr), 0);

    foreach (VEC[k]) begin
      int ep, fin;
      logic arm, exp_data;
      ep = int'(VEC[k][5:4]);
      arm = VEC[k][3];
      exp_data = VEC[k][2];
      fin = int'(VEC[k][1:0]);
      clear_flag(ep);
      check("R8 lone clear", 32'(tr_flag[ep]), 0);
      if (arm) begin
        pkt_arm[ep] = 1'b1;
        @(negedge clk);
        pkt_arm = '0;
      end
      send_token(ep);
      check("R2 R5 resp_data", 32'(resp_data), 32'(exp_data));
      check("R2 R5 resp_nak", 32'(resp_nak), 32'(!exp_data));
      check("R2 resp_ep", 32'(resp_ep), 32'(ep));
      check("R3 R4 no flag at token", 32'(tr_flag[ep]), 0);
      @(negedge clk);
      check("R2 single pulse", 32'(resp_nak | resp_data), 0);
      finish_txn(fin);
      check("R3 R4 flag after handshake", 32'(tr_flag[ep]), 32'(fin == 0));
      check("R11 ready after close", 32'(tok_ready), 1);
    end

    // R8 set and clear in same cycle
    clear_flag(1);
    send_token(1);
    flag_clr[1] = 1'b1;
    finish_txn(0);
    flag_clr = '0;
    check("R8 set wins", 32'(tr_flag[1]), 1);

    // R9 interrupt masking: flags now ep0=0 ep1=1 ep2=1
    clear_flag(2);
    irq_en = 3'b000; @(negedge clk);
    check("R9 masked", 32'(irq), 0);
    irq_en = 3'b010; @(negedge clk);
    check("R9 enabled", 32'(irq), 1);
    irq_en = 3'b101; @(negedge clk);
    check("R9 other mask", 32'(irq), 0);
    irq_en = '0;

    // R11 back-pressure and out-of-range token
    send_token(0);
    tok_valid = 1'b1; tok_ep = 2'd1;
    @(negedge clk);
    check("R11 busy", 32'(tok_ready), 0);
    @(negedge clk);
    check("R11 held not taken", 32'(resp_nak | resp_data), 0);
    finish_txn(0);
    check("R11 ready again", 32'(tok_ready), 1);
    @(negedge clk);
    tok_valid = 1'b0;
    check("R11 held token taken", 32'(resp_nak), 1);
    check("R11 held token ep", 32'(resp_ep), 1);
    finish_txn(0);
    send_token(3);
    check("R11 out of range no resp", 32'(resp_nak | resp_data), 0);
    check("R11 out of range ready", 32'(tok_ready), 1);

    // R10 FIFO clear guard
    fifo_clr_req = 1'b1; @(negedge clk); fifo_clr_req = 1'b0;
    check("R10 clear with DMA off", 32'(out_fifo_clr), 1);
    @(negedge clk);
    check("R10 one-cycle pulse", 32'(out_fifo_clr), 0);
    dma_wr = 1'b1; dma_wdata = 1'b1; @(negedge clk); dma_wr = 1'b0;
    check("R10 dma_on", 32'(dma_on), 1);
    fifo_clr_req = 1'b1; @(negedge clk); fifo_clr_req = 1'b0;
    check("R10 clear ignored", 32'(out_fifo_clr), 0);
    dma_wr = 1'b1; dma_wdata = 1'b0; @(negedge clk); dma_wr = 1'b0;
    fifo_clr_req = 1'b1; @(negedge clk); fifo_clr_req = 1'b0;
    check("R10 clear after disable", 32'(out_fifo_clr), 1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule